// File: doc/BRIEF.md
# Indexed-Port Byte Memory Bridge

This block is a slave on a byte-wide synchronous port bus. It holds a byte memory of 4096 locations. Software does not map that memory into its address space. It reaches the memory through a small window of port registers instead. The host first loads a 12-bit location pointer in two steps: the low byte, then the upper nibble. It then reads or writes a separate data port, and that access lands on the location the pointer names.

The pointer is not advanced by data accesses. Back-to-back data-port operations all hit the same byte until software loads a new pointer. Reset returns the pointer to location zero and leaves the memory contents as they were, so stored data survives a reset of the surrounding logic. A read delivers its byte on `rdata` one clock after the read strobe. In every other cycle `rdata` is 0x00.

Top module: `nvb_port_bridge`

## Requirements
- R1: A write to port 0 (`port_addr` = 2'd0) loads `wdata[7:0]` into bits 7..0 of the location pointer and leaves bits 11..8 unchanged.
- R2: A write to port 1 (`port_addr` = 2'd1) loads `wdata[3:0]` into pointer bits 11..8. `wdata[7:4]` is discarded.
- R3: A read of port 3 (`port_addr` = 2'd3) places the byte stored at the current 12-bit pointer on `rdata` in the cycle after `rd_en` is sampled.
- R4: A write to port 3 stores `wdata` at the current 12-bit pointer. A later read at that pointer returns the stored value.
- R5: Data-port reads and writes do not change the pointer. Repeated data-port accesses reach the same location.
- R6: Port 2 is unused. A read of port 2, port 0 or port 1 returns 0x00 on `rdata` in the following cycle. A write to port 2 changes neither the pointer nor any memory byte.
- R7: In a cycle that follows a cycle with no data-port read, `rdata` is 0x00.
- R8: Synchronous active-low reset clears the pointer to 0 and drives `rdata` to 0x00. Memory contents are kept through reset.
- R9: When `rd_en` and `wr_en` are both high on port 3 in the same cycle, `rdata` returns the byte held before that write, and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| port_addr | input | 2 | Port select: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wr_en | input | 1 | Write strobe for the selected port, one cycle per access |
| rd_en | input | 1 | Read strobe for the selected port, one cycle per access |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid the cycle after `rd_en`, 0x00 otherwise |

## Verification
Pointer writes take effect at the edge that samples them, so the next data-port access already uses the new location. Each read result is due exactly one cycle after its strobe. The driver pushes the expected byte into a queue in the same cycle it raises `rd_en`. The monitor registers the strobe at the rising edge and compares at the following falling edge, which is the only point where that byte is valid. Checks that `rdata` is zero in idle cycles are taken at the falling edge of the cycle after a non-read. The bench keeps its own byte model, written only by its write tasks, and takes its expected values from that model.

// File: rtl/nvb_pkg.sv
// Package: shared port encoding and sizes for the indexed-port byte memory bridge.
// Assumes a 2-bit port select; the encoding is fixed because software depends on it.
package nvb_pkg;

    typedef enum logic [1:0] {
        PORT_PTR_LO = 2'd0,
        PORT_PTR_HI = 2'd1,
        PORT_SPARE  = 2'd2,
        PORT_DATA   = 2'd3
    } port_sel_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/nvb_decode.sv
// Module: nvb_decode
// Turns the bus strobes and port select into one-hot style enables for the
// pointer halves and the data port. Assumes the host never raises a strobe
// for more than one cycle per access. Port 2 produces no enable at all.
module nvb_decode
    import nvb_pkg::*;
(
    input  logic [1:0] port_addr,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic       ptr_lo_we,
    output logic       ptr_hi_we,
    output logic       data_we,
    output logic       data_re
);

    // Purpose: combinational port decode.
    always_comb begin
        ptr_lo_we = wr_en && (port_addr == PORT_PTR_LO);
        ptr_hi_we = wr_en && (port_addr == PORT_PTR_HI);
        data_we   = wr_en && (port_addr == PORT_DATA);
        data_re   = rd_en && (port_addr == PORT_DATA);
    end

endmodule

// File: rtl/nvb_ptr_latch.sv
// Module: nvb_ptr_latch
// Holds the location pointer as a low byte and an upper field of
// ADDR_W-8 bits, loaded by separate writes. Assumes ADDR_W > 8. The pointer
// never advances by itself; only the two load enables change it.
module nvb_ptr_latch #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [LO_W-1:0]   wdata,
    output logic [ADDR_W-1:0] ptr
);

    localparam int unsigned HI_W = ADDR_W - LO_W;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    // Purpose: load the low pointer byte, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_we) lo_q <= wdata;
    end

    generate
        if (HI_W < LO_W) begin : g_narrow_hi
            // Purpose: load the upper pointer field from the low bits of the byte.
            always_ff @(posedge clk) begin
                if (!rst_n)     hi_q <= '0;
                else if (hi_we) hi_q <= wdata[HI_W-1:0];
            end
        end else begin : g_full_hi
            // Purpose: load the upper pointer field, zero-extending the byte.
            always_ff @(posedge clk) begin
                if (!rst_n)     hi_q <= '0;
                else if (hi_we) hi_q <= HI_W'(wdata);
            end
        end
    endgenerate

    assign ptr = {hi_q, lo_q};

    // R5: the pointer moves only on a pointer-load write.
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we && !hi_we) |=> $stable(ptr));

endmodule

// File: rtl/nvb_store.sv
// Module: nvb_store
// Byte array of 2**ADDR_W locations with one synchronous read and one write
// port on a shared address. Read is read-before-write. The array has no reset,
// so contents survive a reset of the control logic.
module nvb_store #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Purpose: write the addressed byte.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Purpose: capture the addressed byte as it was before any same-edge write.
    always_ff @(posedge clk) begin
        if (re) rdata <= cells[addr];
    end

endmodule

// File: rtl/nvb_port_bridge.sv
// Module: nvb_port_bridge (top)
// Slave on a byte-wide port bus that reaches a 2**ADDR_W-byte memory through a
// pointer (ports 0 and 1) and a data port (port 3). Read data appears one cycle
// after rd_en; rdata is zero in every other cycle. Reset clears the pointer and
// the read path only.
module nvb_port_bridge
    import nvb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       port_addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic              ptr_lo_we;
    logic              ptr_hi_we;
    logic              data_we;
    logic              data_re;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] store_q;
    logic              rvalid_q;

    nvb_decode u_decode (
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .ptr_lo_we (ptr_lo_we),
        .ptr_hi_we (ptr_hi_we),
        .data_we   (data_we),
        .data_re   (data_re)
    );

    nvb_ptr_latch #(.ADDR_W(ADDR_W), .LO_W(BYTE_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (ptr_lo_we),
        .hi_we (ptr_hi_we),
        .wdata (wdata),
        .ptr   (ptr)
    );

    nvb_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .addr  (ptr),
        .we    (data_we),
        .re    (data_re),
        .wdata (wdata),
        .rdata (store_q)
    );

    // Purpose: remember that a data-port read happened in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid_q <= 1'b0;
        else        rvalid_q <= data_re;
    end

    // Purpose: return the fetched byte only in its valid cycle, else zero.
    always_comb begin
        rdata = rvalid_q ? store_q : '0;
    end

    // R8: reset forces the read bus to zero.
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

    // R6: reads of ports other than the data port return zero.
    a_r6_spare_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (port_addr != PORT_DATA)) |=> (rdata == '0));

    // R7: no data-port read means a zero read bus in the next cycle.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

endmodule

// File: tb/sim_nvb_port_bridge.sv
module sim_nvb_port_bridge;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];
    logic  due = 1'b0;
    logic [7:0] model [4096];
    logic [11:0] cur_ptr = 12'h000;

    nvb_port_bridge u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_addr (port_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: note a read strobe at the edge, compare at the next falling edge.
    always @(posedge clk) due <= rd_en;

    always @(negedge clk) begin
        if (due) begin
            if (sb_q.size() == 0) begin
                errors++;
                checks++;
                $display("FAIL scoreboard empty: rdata=%h expected none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic cycle();
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic port_wr(input logic [1:0] p, input logic [7:0] d);
        port_addr = p; wdata = d; wr_en = 1'b1;
        if (p == 2'd0) cur_ptr[7:0]  = d;
        if (p == 2'd1) cur_ptr[11:8] = d[3:0];
        if (p == 2'd3) model[cur_ptr] = d;
        cycle();
    endtask

    task automatic port_rd(input logic [1:0] p, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        port_addr = p; rd_en = 1'b1;
        cycle();
    endtask

    // Upper nibble of the high write carries junk to exercise R2.
    task automatic set_ptr(input logic [11:0] a);
        port_wr(2'd0, a[7:0]);
        port_wr(2'd1, {~a[11:8], a[11:8]});
    endtask

    task automatic mem_wr(input logic [11:0] a, input logic [7:0] d);
        set_ptr(a);
        port_wr(2'd3, d);
    endtask

    task automatic mem_rd(input logic [11:0] a, input string tag);
        set_ptr(a);
        port_rd(2'd3, model[a], tag);
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if (rdata !== 8'h00) begin
            errors++;
            $display("FAIL %s: rdata=%h expected 00", tag, rdata);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R8 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 and R3: writes then reads at several locations, including both ends.
        mem_wr(12'h000, 8'h11);
        mem_wr(12'hFFF, 8'hEE);
        mem_wr(12'h5A3, 8'h3C);
        mem_wr(12'hA5C, 8'hC3);
        mem_rd(12'h000, "R3 read loc 000");
        mem_rd(12'hFFF, "R3 read loc FFF");
        mem_rd(12'h5A3, "R4 read back 5A3");
        mem_rd(12'hA5C, "R4 read back A5C");

        // R2: high write with junk upper bits 0xF5 selects 0x5A3.
        port_wr(2'd0, 8'hA3);
        port_wr(2'd1, 8'hF5);
        port_rd(2'd3, 8'h3C, "R2 high nibble only");

        // R1: low byte reload keeps the high nibble (5) -> 0x55C.
        port_wr(2'd0, 8'h5C);
        port_wr(2'd3, 8'h77);
        mem_rd(12'h55C, "R1 low byte keeps high");

        // R5: pointer holds across data accesses.
        mem_wr(12'h124, 8'h99);
        set_ptr(12'h123);
        port_wr(2'd3, 8'h01);
        port_wr(2'd3, 8'h02);
        port_rd(2'd3, 8'h02, "R5 repeated write same loc");
        port_rd(2'd3, 8'h02, "R5 repeated read same loc");
        mem_rd(12'h124, "R5 neighbour untouched");

        // R7: idle cycle after a read returns zero.
        @(negedge clk);
        check_zero("R7 idle after read");

        // R6: spare and pointer ports read as zero; spare write ignored.
        set_ptr(12'h5A3);
        port_rd(2'd2, 8'h00, "R6 read spare port");
        port_rd(2'd0, 8'h00, "R6 read pointer low port");
        port_rd(2'd1, 8'h00, "R6 read pointer high port");
        port_addr = 2'd2; wdata = 8'hFF; wr_en = 1'b1;
        cycle();
        port_rd(2'd3, 8'h3C, "R6 spare write ignored");

        // R9: read and write together return the old byte, then the new one.
        mem_wr(12'h0F0, 8'h40);
        port_addr = 2'd3; wdata = 8'h41; wr_en = 1'b1; rd_en = 1'b1;
        sb_q.push_back('{exp: 8'h40, tag: "R9 collision old byte"});
        model[12'h0F0] = 8'h41;
        cycle();
        port_rd(2'd3, 8'h41, "R9 collision new byte stored");

        // R8: reset clears the pointer but keeps memory.
        set_ptr(12'h5A3);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_zero("R8 rdata in reset");
        rst_n = 1'b1;
        port_rd(2'd3, 8'h11, "R8 pointer cleared to 000");
        mem_rd(12'hA5C, "R8 memory kept");
        mem_rd(12'h0F0, "R8 memory kept 0F0");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule